// File: doc/BRIEF.md
# Per-Port Receive Statistics Counters

This block keeps a bank of receive statistics for each of a parameterised number of ports (four by default). An upstream stage that has already measured and classified each frame presents one frame summary per cycle: the port it arrived on, its length in bytes with the CRC included, and flags for a bad FCS or alignment, a receive error, a drop marking, the destination address class and whether the frame was parsed starting at L2. The block routes that summary to the counters of the addressed port and updates each of them in a single cycle.

The counters cover a frame-size histogram, short and long frames split by FCS status, multicast and broadcast frames, good and errored frame totals, all received bytes, and dropped frames and bytes. They saturate at their maximum value rather than wrapping. A register-style read port selects a port and a counter index and returns the value one cycle later. A global mode input makes every read also zero the counter it returns. The upper legal length is held in a writable register.

Top module: `rxs_stats`

## Requirements
- R1: After reset every counter reads 0, the maximum-length register holds 1518, and `rd_valid` is low.
- R2: A frame with 64 <= length <= maximum increments exactly one size bin: index 7 (length 64), 8 (65..127), 9 (128..255), 10 (256..511), 11 (512..1023), 12 (1024..1518), 13 (1519..maximum).
- R3: A frame shorter than 64 bytes increments index 15 (runt) when `in_fcs_err` is 0 and index 16 (fragment) when it is 1, and no size bin.
- R4: A frame longer than the maximum increments index 17 (oversize) when `in_fcs_err` is 0 and index 18 (jabber) when it is 1, and no size bin; a pulse on `max_wr` loads `max_wdata` as the new maximum for later frames.
- R5: Every frame with `in_fcs_err` set increments index 14, whatever its length.
- R6: With `in_l2` set, `in_dclass` 1 increments index 5 (multicast) and `in_dclass` 2 increments index 6 (broadcast); classes 0 and 3, or `in_l2` clear, increment neither.
- R7: Every frame adds its length to index 2 (48-bit byte total) and increments index 0 when `in_rx_err` is 0 or index 1 (16-bit error count) when it is 1.
- R8: A frame with `in_drop` set increments index 3 and adds its length to index 4.
- R9: A read pulse on `rd_en` gives `rd_valid` high and `rd_data` equal to the selected counter's value on the next cycle; an index above 18 or a port out of range returns 0.
- R10: With `rd_clr_mode` high a read zeroes the counter it returns; with it low the counter is unchanged.
- R11: When a clearing read and an update hit the same counter in the same cycle, the read returns the old value and the counter then holds only the new increment.
- R12: Counters stop at their all-ones maximum (32 bits, 48 for index 2, 16 for index 1) and never wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame summary present this cycle |
| in_port | input | PORT_W | Receiving port |
| in_len | input | LEN_W | Frame length in bytes including CRC |
| in_fcs_err | input | 1 | FCS or alignment error |
| in_rx_err | input | 1 | Receive error on the link |
| in_drop | input | 1 | Frame marked for drop |
| in_dclass | input | 2 | Destination class: 0 unicast, 1 multicast, 2 broadcast, 3 reserved |
| in_l2 | input | 1 | Frame parsed starting at L2 |
| max_wr | input | 1 | Load the maximum-length register |
| max_wdata | input | LEN_W | New maximum length |
| rd_clr_mode | input | 1 | Reads clear the counter they return |
| rd_en | input | 1 | Read request |
| rd_port | input | PORT_W | Port to read |
| rd_idx | input | IDX_W | Counter index to read |
| rd_valid | output | 1 | Read data present |
| rd_data | output | OCT_W | Counter value |

## Verification
On every cycle the assertions check that no counter ever decreases except by a clearing read, that a clearing read leaves zero when no frame lands on that port, that read data matches the addressed counter one cycle later, and that multicast and broadcast never rise together. Only the bench scenarios show that each length lands in the right bin or error counter, that the programmed maximum moves the oversize boundary, the byte sums, the same-cycle clear-and-update outcome, and saturation of the 16-bit error count after more than 65535 frames.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    localparam int NCNT  = 19;
    localparam int IDX_W = $clog2(NCNT);

    // counter index map (the read port decodes these)
    localparam int C_GOOD_PKTS = 0;
    localparam int C_ERR_PKTS  = 1;
    localparam int C_ALL_OCTS  = 2;
    localparam int C_DROP_PKTS = 3;
    localparam int C_DROP_OCTS = 4;
    localparam int C_MCAST     = 5;
    localparam int C_BCAST     = 6;
    localparam int C_H64       = 7;
    localparam int C_H65       = 8;
    localparam int C_H128      = 9;
    localparam int C_H256      = 10;
    localparam int C_H512      = 11;
    localparam int C_H1024     = 12;
    localparam int C_H1519     = 13;
    localparam int C_FCS       = 14;
    localparam int C_RUNT      = 15;
    localparam int C_FRAG      = 16;
    localparam int C_OVER      = 17;
    localparam int C_JABBER    = 18;

    typedef enum logic [1:0] {
        DC_UNI   = 2'd0,
        DC_MULTI = 2'd1,
        DC_BROAD = 2'd2,
        DC_RSVD  = 2'd3
    } dclass_e;

    function automatic int cnt_width(input int idx, input int cw, input int ow, input int ew);
        if (idx == C_ALL_OCTS) return ow;
        if (idx == C_ERR_PKTS) return ew;
        return cw;
    endfunction

    function automatic bit is_byte_cnt(input int idx);
        return (idx == C_ALL_OCTS) || (idx == C_DROP_OCTS);
    endfunction

endpackage

// File: rtl/rxs_classify.sv
module rxs_classify
    import rxs_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 64
) (
    input  logic [LEN_W-1:0] len,
    input  logic             fcs_err,
    input  logic             rx_err,
    input  logic             drop,
    input  logic [1:0]       dclass,
    input  logic             l2,
    input  logic [LEN_W-1:0] max_len,
    output logic [NCNT-1:0]  hit
);

    always_comb begin
        hit = '0;
        hit[C_ALL_OCTS] = 1'b1;
        if (rx_err) hit[C_ERR_PKTS]  = 1'b1;
        else        hit[C_GOOD_PKTS] = 1'b1;
        if (drop) begin
            hit[C_DROP_PKTS] = 1'b1;
            hit[C_DROP_OCTS] = 1'b1;
        end
        if (fcs_err) hit[C_FCS] = 1'b1;
        if (l2) begin
            if (dclass == DC_MULTI) hit[C_MCAST] = 1'b1;
            if (dclass == DC_BROAD) hit[C_BCAST] = 1'b1;
        end
        // length classes: short, long, else one histogram bin
        if (len < LEN_W'(MIN_LEN)) begin
            if (fcs_err) hit[C_FRAG] = 1'b1;
            else         hit[C_RUNT] = 1'b1;
        end else if (len > max_len) begin
            if (fcs_err) hit[C_JABBER] = 1'b1;
            else         hit[C_OVER]   = 1'b1;
        end else if (len <= LEN_W'(64)) begin
            hit[C_H64] = 1'b1;
        end else if (len <= LEN_W'(127)) begin
            hit[C_H65] = 1'b1;
        end else if (len <= LEN_W'(255)) begin
            hit[C_H128] = 1'b1;
        end else if (len <= LEN_W'(511)) begin
            hit[C_H256] = 1'b1;
        end else if (len <= LEN_W'(1023)) begin
            hit[C_H512] = 1'b1;
        end else if (len <= LEN_W'(1518)) begin
            hit[C_H1024] = 1'b1;
        end else begin
            hit[C_H1519] = 1'b1;
        end
    end

endmodule

// File: rtl/rxs_sat_cnt.sv
module rxs_sat_cnt #(
    parameter int W  = 32,
    parameter int AW = 16,
    parameter int OW = 48
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_en,
    input  logic [AW-1:0] inc_amt,
    input  logic          clr,
    output logic [OW-1:0] value
);

    localparam int SW = ((W > AW) ? W : AW) + 1;
    localparam logic [SW-1:0] MAXV = {{(SW-W){1'b0}}, {W{1'b1}}};

    logic [W-1:0]  cnt_d, cnt_q;
    logic [SW-1:0] base, add, sum;

    always_comb begin
        // a clearing read drops the old value but keeps this cycle's increment
        base  = clr ? '0 : {{(SW-W){1'b0}}, cnt_q};
        add   = inc_en ? {{(SW-AW){1'b0}}, inc_amt} : '0;
        sum   = base + add;
        cnt_d = (sum > MAXV) ? {W{1'b1}} : sum[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign value = OW'(cnt_q);

endmodule

// File: rtl/rxs_stats.sv
module rxs_stats
    import rxs_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int LEN_W     = 16,
    parameter int CNT_W     = 32,
    parameter int OCT_W     = 48,
    parameter int ERR_W     = 16,
    parameter int MIN_LEN   = 64,
    parameter int MAX_RST   = 1518,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PORT_W-1:0] in_port,
    input  logic [LEN_W-1:0]  in_len,
    input  logic              in_fcs_err,
    input  logic              in_rx_err,
    input  logic              in_drop,
    input  logic [1:0]        in_dclass,
    input  logic              in_l2,
    input  logic              max_wr,
    input  logic [LEN_W-1:0]  max_wdata,
    input  logic              rd_clr_mode,
    input  logic              rd_en,
    input  logic [PORT_W-1:0] rd_port,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [OCT_W-1:0]  rd_data
);

    typedef struct packed {
        logic [LEN_W-1:0] max_len;
        logic             rd_valid;
        logic [OCT_W-1:0] rd_data;
    } state_t;

    state_t st_d, st_q;

    logic [NCNT-1:0] hit;
    logic [NUM_PORTS-1:0][NCNT-1:0][OCT_W-1:0] cnt_val;

    rxs_classify #(
        .LEN_W   (LEN_W),
        .MIN_LEN (MIN_LEN)
    ) u_classify (
        .len     (in_len),
        .fcs_err (in_fcs_err),
        .rx_err  (in_rx_err),
        .drop    (in_drop),
        .dclass  (in_dclass),
        .l2      (in_l2),
        .max_len (st_q.max_len),
        .hit     (hit)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        for (genvar i = 0; i < NCNT; i++) begin : g_cnt
            localparam int W = cnt_width(i, CNT_W, OCT_W, ERR_W);
            logic             en, clr;
            logic [LEN_W-1:0] amt;
            assign en  = in_valid && (in_port == PORT_W'(p)) && hit[i];
            assign amt = is_byte_cnt(i) ? in_len : LEN_W'(1);
            assign clr = rd_en && rd_clr_mode && (rd_port == PORT_W'(p))
                         && (rd_idx == IDX_W'(i));
            rxs_sat_cnt #(
                .W  (W),
                .AW (LEN_W),
                .OW (OCT_W)
            ) u_cnt (
                .clk     (clk),
                .rst_n   (rst_n),
                .inc_en  (en),
                .inc_amt (amt),
                .clr     (clr),
                .value   (cnt_val[p][i])
            );
        end
    end

    always_comb begin
        st_d          = st_q;
        st_d.max_len  = max_wr ? max_wdata : st_q.max_len;
        st_d.rd_valid = rd_en;
        st_d.rd_data  = '0;
        if (rd_en && (int'(rd_idx) < NCNT) && (int'(rd_port) < NUM_PORTS))
            st_d.rd_data = cnt_val[rd_port][rd_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.max_len  <= LEN_W'(MAX_RST);
            st_q.rd_valid <= 1'b0;
            st_q.rd_data  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid = st_q.rd_valid;
    assign rd_data  = st_q.rd_data;

endmodule

// File: rtl/rxs_stats_chk.sv
module rxs_stats_chk
    import rxs_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int OCT_W     = 48,
    parameter int PORT_W    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [PORT_W-1:0] in_port,
    input logic              rd_clr_mode,
    input logic              rd_en,
    input logic [PORT_W-1:0] rd_port,
    input logic [IDX_W-1:0]  rd_idx,
    input logic              rd_valid,
    input logic [OCT_W-1:0]  rd_data,
    input logic [NUM_PORTS-1:0][NCNT-1:0][OCT_W-1:0] cnt_val
);

    // R9: read valid one cycle after every request, never otherwise
    a_r9_rd_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == $past(rd_en) || !$past(rst_n));

    // R9: read data equals the addressed counter as it stood at the request
    a_r9_rd_data_match: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && int'(rd_idx) < NCNT && int'(rd_port) < NUM_PORTS)
        |=> rd_data == $past(cnt_val[rd_port][rd_idx]));

    // R10: clearing read without a colliding frame leaves zero
    a_r10_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_clr_mode && int'(rd_idx) < NCNT && int'(rd_port) < NUM_PORTS
         && !(in_valid && in_port == rd_port))
        |=> cnt_val[$past(rd_port)][$past(rd_idx)] == '0);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
        // R6: multicast and broadcast never rise together
        a_r6_class_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> !((cnt_val[p][C_MCAST] != $past(cnt_val[p][C_MCAST]))
                        && (cnt_val[p][C_BCAST] != $past(cnt_val[p][C_BCAST]))));
        for (genvar i = 0; i < NCNT; i++) begin : g_i
            // R12: without a clear a counter never goes down (no wrap)
            a_r12_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
                !(rd_en && rd_clr_mode && rd_port == PORT_W'(p) && rd_idx == IDX_W'(i))
                |=> cnt_val[p][i] >= $past(cnt_val[p][i]));
        end
    end

endmodule

bind rxs_stats rxs_stats_chk #(
    .NUM_PORTS (NUM_PORTS),
    .OCT_W     (OCT_W),
    .PORT_W    (PORT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_port     (in_port),
    .rd_clr_mode (rd_clr_mode),
    .rd_en       (rd_en),
    .rd_port     (rd_port),
    .rd_idx      (rd_idx),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .cnt_val     (cnt_val)
);

// File: tb/tb_rxs_stats.sv
`timescale 1ns/1ps
module tb_rxs_stats;

    localparam int I_GOOD = 0,  I_ERR = 1,  I_OCT = 2,  I_DPK = 3,  I_DOC = 4;
    localparam int I_MC = 5,    I_BC = 6,   I_H64 = 7,  I_H65 = 8,  I_H128 = 9;
    localparam int I_H256 = 10, I_H512 = 11, I_H1024 = 12, I_H1519 = 13;
    localparam int I_FCS = 14,  I_RUNT = 15, I_FRAG = 16, I_OVER = 17, I_JAB = 18;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_fcs_err, in_rx_err, in_drop, in_l2;
    logic [1:0]  in_port, in_dclass, rd_port;
    logic [15:0] in_len, max_wdata;
    logic        max_wr, rd_clr_mode, rd_en, rd_valid;
    logic [4:0]  rd_idx;
    logic [47:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rxs_stats dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_port(in_port),
        .in_len(in_len), .in_fcs_err(in_fcs_err), .in_rx_err(in_rx_err),
        .in_drop(in_drop), .in_dclass(in_dclass), .in_l2(in_l2),
        .max_wr(max_wr), .max_wdata(max_wdata), .rd_clr_mode(rd_clr_mode),
        .rd_en(rd_en), .rd_port(rd_port), .rd_idx(rd_idx),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // all tasks start and end on a falling edge
    task automatic send(input int port, input int len, input bit fcs, input bit rxe,
                        input bit drp, input int dc, input bit l2, input int n);
        in_valid = 1'b1; in_port = 2'(port); in_len = 16'(len);
        in_fcs_err = fcs; in_rx_err = rxe; in_drop = drp;
        in_dclass = 2'(dc); in_l2 = l2;
        repeat (n) @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic rd(input int port, input int idx, output longint data, output bit vld);
        rd_en = 1'b1; rd_port = 2'(port); rd_idx = 5'(idx);
        @(negedge clk);
        rd_en = 1'b0;
        data = longint'(rd_data);
        vld  = rd_valid;
    endtask

    task automatic rdchk(input string tag, input int port, input int idx, input longint exp);
        longint d; bit v;
        rd(port, idx, d, v);
        check(tag, d, exp);
    endtask

    task automatic t_reset;
        check("R1 rd_valid after reset", longint'(rd_valid), 0);
        rdchk("R1 good count zero", 0, I_GOOD, 0);
        rdchk("R1 octets zero", 3, I_OCT, 0);
        rdchk("R1 jabber zero", 2, I_JAB, 0);
        // default maximum 1518: 1518 is in range, 1519 is oversize
        send(0, 1518, 0, 0, 0, 0, 0, 1);
        send(0, 1519, 0, 0, 0, 0, 0, 1);
        rdchk("R1 max 1518 in bin", 0, I_H1024, 1);
        rdchk("R1 1519 oversize", 0, I_OVER, 1);
    endtask

    task automatic t_hist;
        int lens[12] = '{64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 1518, 1024};
        foreach (lens[k]) send(1, lens[k], 0, 0, 0, 0, 0, 1);
        rdchk("R2 bin 64", 1, I_H64, 1);
        rdchk("R2 bin 65..127", 1, I_H65, 2);
        rdchk("R2 bin 128..255", 1, I_H128, 2);
        rdchk("R2 bin 256..511", 1, I_H256, 2);
        rdchk("R2 bin 512..1023", 1, I_H512, 2);
        rdchk("R2 bin 1024..1518", 1, I_H1024, 3);
        rdchk("R2 bin 1519+ empty", 1, I_H1519, 0);
        // R4: raise the maximum
        max_wr = 1'b1; max_wdata = 16'd2000;
        @(negedge clk);
        max_wr = 1'b0;
        send(1, 1519, 0, 0, 0, 0, 0, 1);
        send(1, 2000, 0, 0, 0, 0, 0, 1);
        send(1, 2001, 0, 0, 0, 0, 0, 1);
        send(1, 2001, 1, 0, 0, 0, 0, 1);
        rdchk("R2 bin 1519..max", 1, I_H1519, 2);
        rdchk("R4 oversize", 1, I_OVER, 1);
        rdchk("R4 jabber", 1, I_JAB, 1);
        rdchk("R5 fcs long frame", 1, I_FCS, 1);
    endtask

    task automatic t_short;
        send(2, 40, 0, 0, 0, 0, 0, 1);
        send(2, 63, 1, 0, 0, 0, 0, 1);
        send(2, 10, 1, 0, 0, 0, 0, 1);
        rdchk("R3 runt", 2, I_RUNT, 1);
        rdchk("R3 fragment", 2, I_FRAG, 2);
        rdchk("R3 no bin for short", 2, I_H64, 0);
        rdchk("R5 fcs short frames", 2, I_FCS, 2);
    endtask

    task automatic t_class;
        send(0, 100, 0, 0, 0, 1, 1, 1);
        send(0, 100, 0, 0, 0, 2, 1, 1);
        send(0, 100, 0, 0, 0, 2, 1, 1);
        send(0, 100, 0, 0, 0, 1, 0, 1);
        send(0, 100, 0, 0, 0, 2, 0, 1);
        send(0, 100, 0, 0, 0, 3, 1, 1);
        rdchk("R6 multicast", 0, I_MC, 1);
        rdchk("R6 broadcast", 0, I_BC, 2);
    endtask

    task automatic t_bytes;
        send(0, 200, 0, 0, 0, 0, 0, 1);
        send(0, 300, 0, 1, 1, 0, 0, 1);
        send(0, 70, 0, 0, 1, 0, 0, 1);
        // port 0 so far: 1518 + 1519 + 6*100 + 200 + 300 + 70
        rdchk("R7 byte total", 0, I_OCT, 4207);
        rdchk("R7 good frames", 0, I_GOOD, 10);
        rdchk("R7 error frames", 0, I_ERR, 1);
        rdchk("R8 drop frames", 0, I_DPK, 2);
        rdchk("R8 drop bytes", 0, I_DOC, 370);
    endtask

    task automatic t_read;
        longint d; bit v;
        rd(1, 25, d, v);
        check("R9 bad index valid", longint'(v), 1);
        check("R9 bad index data", d, 0);
        rd(1, I_H64, d, v);
        check("R9 valid on read", longint'(v), 1);
        @(negedge clk);
        check("R9 valid drops", longint'(rd_valid), 0);
    endtask

    task automatic t_clear;
        rdchk("R10 plain read", 1, I_H1024, 3);
        rdchk("R10 plain read keeps", 1, I_H1024, 3);
        rd_clr_mode = 1'b1;
        rdchk("R10 clear read returns", 1, I_H1024, 3);
        rdchk("R10 cleared", 1, I_H1024, 0);
        rd_clr_mode = 1'b0;
        send(1, 1024, 0, 0, 0, 0, 0, 1);
        rdchk("R10 counts after clear", 1, I_H1024, 1);
    endtask

    task automatic t_collide;
        longint d;
        rd_clr_mode = 1'b1;
        in_valid = 1'b1; in_port = 2'd2; in_len = 16'd40;
        in_fcs_err = 1'b0; in_rx_err = 1'b0; in_drop = 1'b0;
        in_dclass = 2'd0; in_l2 = 1'b0;
        rd_en = 1'b1; rd_port = 2'd2; rd_idx = 5'(I_RUNT);
        @(negedge clk);
        in_valid = 1'b0; rd_en = 1'b0;
        d = longint'(rd_data);
        check("R11 collide returns old", d, 1);
        rdchk("R11 holds new increment", 2, I_RUNT, 1);
        rdchk("R11 then zero", 2, I_RUNT, 0);
        rd_clr_mode = 1'b0;
    endtask

    task automatic t_sat;
        send(3, 64, 0, 1, 0, 0, 0, 65540);
        rdchk("R12 error count saturates", 3, I_ERR, 65535);
        rdchk("R12 good untouched", 3, I_GOOD, 0);
        rdchk("R12 32-bit bin", 3, I_H64, 65540);
        rdchk("R12 wide byte total", 3, I_OCT, 65540 * 64);
        rd_clr_mode = 1'b1;
        rdchk("R12 clear saturated", 3, I_ERR, 65535);
        rdchk("R12 restart from zero", 3, I_ERR, 0);
        rd_clr_mode = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_port = '0; in_len = '0;
        in_fcs_err = 1'b0; in_rx_err = 1'b0; in_drop = 1'b0;
        in_dclass = '0; in_l2 = 1'b0; max_wr = 1'b0; max_wdata = '0;
        rd_clr_mode = 1'b0; rd_en = 1'b0; rd_port = '0; rd_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_hist;
        t_short;
        t_class;
        t_bytes;
        t_read;
        t_clear;
        t_collide;
        t_sat;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule